// File: doc/BRIEF.md
# Condition Register Boolean Unit

This unit keeps a 32-bit condition register and carries out the single-bit Boolean instructions and the 4-bit field copy of a fixed-width 32-bit instruction format. Each cycle it may take one instruction word, marked by a valid strobe. It decodes the opcode fields and takes three 5-bit bit indices from the word. It combines two selected register bits and writes the result into one destination bit. The update takes effect at the next rising clock edge.

The register numbers its bits MSB-first. Index 0 is the most significant bit, and each group of four indices forms one field: less-than, greater-than, equal, summary-overflow. A synchronous load port sets the register for initialisation, and a read port shows its current contents. An encoding the unit does not recognise raises an illegal flag in the same cycle and leaves the register as it was.

Top module: `cr_bool_unit`

## Requirements
- R1: A valid word is a candidate only when word bits [31:26] equal 19. The fields are taken from fixed positions: destination index BT from [25:21], source A index BA from [20:16], source B index BB from [15:11], the 10-bit function code from [10:1], and the last bit from [0]. Function code 129 writes CR[BT] = CR[BA] AND NOT CR[BB]; with all indices 0 the word is 0x4C000102.
- R2: Index i addresses register bit 31-i, so index 0 is the MSB. BT, BA and BB may each lie in any 4-bit field, independently of the others.
- R3: The function codes select CR[BT] as follows: 257 A AND B, 449 A OR B, 417 A OR NOT B, 225 NOT(A AND B), 33 NOT(A OR B), 193 A XOR B, 289 NOT(A XOR B).
- R4: A bit instruction changes only CR[BT]. The other 31 bits keep their values.
- R5: AND-with-complement with BA equal to BB clears CR[BT].
- R6: Function code 0 copies the field selected by word bits [25:23] (register bits 31-4f down to 28-4f) from the field selected by bits [20:18]. Bits [22:21] and [17:11] must be zero.
- R7: The illegal output is high in the same cycle, and the register is left unchanged, when instValid is high and any of the following holds: the opcode is not 19, bit [0] is set, the function code is not listed in R1, R3 or R6, or a field copy has a nonzero reserved bit. When instValid is low, illegal is low.
- R8: Instructions issue back to back without a stall. An instruction reads the result that the instruction in the previous cycle wrote.
- R9: When loadEn is high, the register takes loadData at the clock edge. This takes priority over any instruction in the same cycle.
- R10: A synchronous reset clears the register to 0. With instValid and loadEn both low, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | Instruction word is present this cycle |
| instWord | input | 32 | Instruction word |
| loadEn | input | 1 | Load the register from loadData |
| loadData | input | 32 | Value for the register load |
| crOut | output | 32 | Current condition register |
| illegal | output | 1 | Valid word not recognised this cycle |

## Verification
The bench writes destination bits that lie in a different field from the sources. A design that mirrored the index order would change the wrong bit, and one that replaced the whole field would clobber the neighbouring bits. It issues AND-with-complement with equal sources, which must give 0; a design that dropped the inversion would copy the source instead. It also runs a dependent pair on consecutive cycles, where a stale read gives the old value. Finally it sends the illegal encodings: bit 0 set, a foreign opcode, and a field copy with a reserved bit set. A design that ignored any of these would either change the register or leave the flag low.

// File: rtl/cr_bool_pkg.sv
package cr_bool_pkg;
  localparam int CR_W   = 32;
  localparam int FLD_W  = 4;
  localparam int NFLD   = CR_W / FLD_W;
  localparam int IDX_W  = $clog2(CR_W);
  localparam int FSEL_W = $clog2(NFLD);
  localparam int XO_W   = 10;
  localparam int PRIM_W = 6;
  localparam logic [PRIM_W-1:0] PRIM_CR = 6'd19;

  localparam logic [XO_W-1:0] XO_FCOPY = 10'd0;
  localparam logic [XO_W-1:0] XO_NOR   = 10'd33;
  localparam logic [XO_W-1:0] XO_ANDC  = 10'd129;
  localparam logic [XO_W-1:0] XO_XOR   = 10'd193;
  localparam logic [XO_W-1:0] XO_NAND  = 10'd225;
  localparam logic [XO_W-1:0] XO_AND   = 10'd257;
  localparam logic [XO_W-1:0] XO_EQV   = 10'd289;
  localparam logic [XO_W-1:0] XO_ORC   = 10'd417;
  localparam logic [XO_W-1:0] XO_OR    = 10'd449;

  typedef enum logic [2:0] {
    OP_AND, OP_ANDC, OP_OR, OP_ORC, OP_NAND, OP_NOR, OP_XOR, OP_EQV
  } boolOp_e;

  typedef struct packed {
    logic              bitWr;
    logic              fieldWr;
    boolOp_e           op;
    logic [IDX_W-1:0]  bt;
    logic [IDX_W-1:0]  ba;
    logic [IDX_W-1:0]  bb;
    logic [FSEL_W-1:0] fd;
    logic [FSEL_W-1:0] fs;
  } crCtl_t;
endpackage

// File: rtl/cr_bool_ctrl.sv
module cr_bool_ctrl
  import cr_bool_pkg::*;
(
  input  logic            instValid,
  input  logic [CR_W-1:0] instWord,
  output crCtl_t          ctl,
  output logic            illegal
);
  logic [PRIM_W-1:0] prim;
  logic [XO_W-1:0]   xo;
  logic              lastBit;
  logic              isBit;
  logic              isField;
  boolOp_e           op;

  assign prim    = instWord[31:26];
  assign xo      = instWord[10:1];
  assign lastBit = instWord[0];

  always_comb begin
    isBit   = 1'b0;
    isField = 1'b0;
    op      = OP_AND;
    if (prim == PRIM_CR && !lastBit) begin
      unique case (xo)
        XO_AND:  begin isBit = 1'b1; op = OP_AND;  end
        XO_ANDC: begin isBit = 1'b1; op = OP_ANDC; end
        XO_OR:   begin isBit = 1'b1; op = OP_OR;   end
        XO_ORC:  begin isBit = 1'b1; op = OP_ORC;  end
        XO_NAND: begin isBit = 1'b1; op = OP_NAND; end
        XO_NOR:  begin isBit = 1'b1; op = OP_NOR;  end
        XO_XOR:  begin isBit = 1'b1; op = OP_XOR;  end
        XO_EQV:  begin isBit = 1'b1; op = OP_EQV;  end
        XO_FCOPY: isField = (instWord[22:21] == '0) && (instWord[17:11] == '0);
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl.bitWr   = instValid && isBit;
    ctl.fieldWr = instValid && isField;
    ctl.op      = op;
    ctl.bt      = instWord[25:21];
    ctl.ba      = instWord[20:16];
    ctl.bb      = instWord[15:11];
    ctl.fd      = instWord[25:23];
    ctl.fs      = instWord[20:18];
  end

  assign illegal = instValid && !isBit && !isField;
endmodule

// File: rtl/cr_bool_dpath.sv
module cr_bool_dpath
  import cr_bool_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            loadEn,
  input  logic [CR_W-1:0] loadData,
  input  crCtl_t          ctl,
  output logic [CR_W-1:0] crQ
);
  localparam logic [IDX_W-1:0]  TOP_BIT = IDX_W'(CR_W - 1);
  localparam logic [FSEL_W-1:0] TOP_FLD = FSEL_W'(NFLD - 1);

  logic [CR_W-1:0]   crNext;
  logic [IDX_W-1:0]  dstPos, aPos, bPos;
  logic [FSEL_W-1:0] dstFld, srcFld;
  logic              opA, opB, res;
  logic [FLD_W-1:0]  srcNib;

  assign dstPos = TOP_BIT - ctl.bt;
  assign aPos   = TOP_BIT - ctl.ba;
  assign bPos   = TOP_BIT - ctl.bb;
  assign dstFld = TOP_FLD - ctl.fd;
  assign srcFld = TOP_FLD - ctl.fs;
  assign opA    = crQ[aPos];
  assign opB    = crQ[bPos];
  assign srcNib = crQ[int'(srcFld)*FLD_W +: FLD_W];

  always_comb begin
    unique case (ctl.op)
      OP_AND:  res = opA & opB;
      OP_ANDC: res = opA & ~opB;
      OP_OR:   res = opA | opB;
      OP_ORC:  res = opA | ~opB;
      OP_NAND: res = ~(opA & opB);
      OP_NOR:  res = ~(opA | opB);
      OP_XOR:  res = opA ^ opB;
      OP_EQV:  res = ~(opA ^ opB);
      default: res = 1'b0;
    endcase
  end

  always_comb begin
    crNext = crQ;
    if (loadEn) crNext = loadData;
    else if (ctl.bitWr) crNext[dstPos] = res;
    else if (ctl.fieldWr) crNext[int'(dstFld)*FLD_W +: FLD_W] = srcNib;
  end

  always_ff @(posedge clk) begin
    if (rst) crQ <= '0;
    else     crQ <= crNext;
  end
endmodule

// File: rtl/cr_bool_unit.sv
module cr_bool_unit
  import cr_bool_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        instValid,
  input  logic [31:0] instWord,
  input  logic        loadEn,
  input  logic [31:0] loadData,
  output logic [31:0] crOut,
  output logic        illegal
);
  crCtl_t ctl;

  cr_bool_ctrl u_ctrl (
    .instValid(instValid),
    .instWord (instWord),
    .ctl      (ctl),
    .illegal  (illegal)
  );

  cr_bool_dpath u_dpath (
    .clk     (clk),
    .rst     (rst),
    .loadEn  (loadEn),
    .loadData(loadData),
    .ctl     (ctl),
    .crQ     (crOut)
  );
endmodule

// File: rtl/cr_bool_chk.sv
module cr_bool_chk (
  input logic        clk,
  input logic        rst,
  input logic        instValid,
  input logic [31:0] instWord,
  input logic        loadEn,
  input logic [31:0] loadData,
  input logic [31:0] crOut,
  input logic        illegal
);
  logic        bitIssue;
  logic [31:0] dstMask;

  assign bitIssue = instValid && !illegal && (instWord[10:1] != 10'd0) && !loadEn;
  assign dstMask  = 32'h8000_0000 >> instWord[25:21];

  // R4: a bit instruction disturbs nothing outside its destination
  a_r4_only_dest: assert property (@(posedge clk) disable iff (rst)
    bitIssue |=> (((crOut ^ $past(crOut)) & ~$past(dstMask)) == 32'h0));

  // R5: A and not A is zero
  a_r5_andc_self: assert property (@(posedge clk) disable iff (rst)
    (bitIssue && instWord[10:1] == 10'd129 && instWord[20:16] == instWord[15:11])
      |=> ((crOut & $past(dstMask)) == 32'h0));

  // R7: an illegal word leaves the register alone
  a_r7_illegal_hold: assert property (@(posedge clk) disable iff (rst)
    (illegal && !loadEn) |=> $stable(crOut));

  // R7: no flag without a valid word
  a_r7_flag_quiet: assert property (@(posedge clk) disable iff (rst)
    !instValid |-> !illegal);

  // R9: load wins
  a_r9_load: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> (crOut == $past(loadData)));

  // R10: idle holds
  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    (!instValid && !loadEn) |=> $stable(crOut));
endmodule

bind cr_bool_unit cr_bool_chk u_chk (.*);

// File: tb/sim_cr_bool_unit.sv
module sim_cr_bool_unit;
  localparam int CLK_P = 10;
  localparam logic [31:0] INIT = 32'hA5F0_0F5A;

  function automatic logic [31:0] enc(input int prim, input int xo, input int bt,
                                      input int ba, input int bb, input int lk);
    logic [31:0] w;
    w = {prim[5:0], bt[4:0], ba[4:0], bb[4:0], xo[9:0], lk[0]};
    return w;
  endfunction

  typedef struct packed {
    logic [31:0] word;
    logic [31:0] expCr;
    logic        expIll;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{enc(19,129,12,0,1,0),  32'hA5F8_0F5A, 1'b0}, // R1 R2 andc, dest in another field
    '{enc(19,129,0,2,2,0),   32'h25F0_0F5A, 1'b0}, // R5 same source clears index 0
    '{enc(19,129,8,0,8,0),   32'hA570_0F5A, 1'b0}, // R1 1 and not 1
    '{enc(19,257,12,8,20,0), 32'hA5F8_0F5A, 1'b0}, // R3 and
    '{enc(19,449,5,12,16,0), 32'hA1F0_0F5A, 1'b0}, // R3 or clears
    '{enc(19,417,12,12,16,0),32'hA5F8_0F5A, 1'b0}, // R3 orc
    '{enc(19,225,30,0,8,0),  32'hA5F0_0F58, 1'b0}, // R3 nand
    '{enc(19,33,13,12,16,0), 32'hA5F4_0F5A, 1'b0}, // R3 nor
    '{enc(19,193,14,0,1,0),  32'hA5F2_0F5A, 1'b0}, // R3 xor
    '{enc(19,289,15,4,12,0), 32'hA5F1_0F5A, 1'b0}, // R3 eqv
    '{enc(19,0,12,0,0,0),    32'hA5FA_0F5A, 1'b0}, // R6 field 0 -> field 3
    '{enc(19,0,28,8,0,0),    32'hA5F0_0F5F, 1'b0}, // R6 field 2 -> field 7
    '{enc(19,5,3,4,5,0),     INIT,          1'b1}, // R7 unknown code
    '{enc(19,129,12,0,1,1),  INIT,          1'b1}, // R7 last bit set
    '{enc(31,129,12,0,1,0),  INIT,          1'b1}, // R7 foreign opcode
    '{enc(19,0,12,0,3,0),    INIT,          1'b1}  // R7 field copy reserved bits
  };

  logic clk = 1'b0, rst = 1'b1;
  logic instValid = 1'b0, loadEn = 1'b0;
  logic [31:0] instWord = '0, loadData = '0;
  logic [31:0] crOut;
  logic illegal;
  int errors = 0, checks = 0;

  always #(CLK_P/2) clk = ~clk;

  cr_bool_unit u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic loadCr(input logic [31:0] v);
    @(negedge clk);
    instValid = 1'b0; loadEn = 1'b1; loadData = v;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  initial begin
    #(CLK_P*100000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset clears", crOut, 32'h0);
    check("R7 no flag when idle", {31'h0, illegal}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      loadCr(INIT);
      instValid = 1'b1; instWord = VECS[i].word;
      #1;
      check($sformatf("R7 vector %0d flag", i), {31'h0, illegal}, {31'h0, VECS[i].expIll});
      @(negedge clk);
      instValid = 1'b0;
      check($sformatf("R4 vector %0d register", i), crOut, VECS[i].expCr);
    end

    // R10: word present but strobe low
    loadCr(INIT);
    instWord = enc(19,129,12,0,1,0);
    #1;
    check("R10 strobe low no flag", {31'h0, illegal}, 32'h0);
    @(negedge clk);
    check("R10 strobe low holds", crOut, INIT);

    // R8: dependent pair on consecutive cycles
    loadCr(32'h0);
    instValid = 1'b1; instWord = enc(19,417,0,1,2,0);
    @(negedge clk);
    instWord = enc(19,129,3,0,1,0);
    @(negedge clk);
    instValid = 1'b0;
    check("R8 back to back", crOut, 32'h9000_0000);

    // R9: load beats a same-cycle instruction
    @(negedge clk);
    loadEn = 1'b1; loadData = 32'h1234_5678;
    instValid = 1'b1; instWord = enc(19,449,0,0,0,0);
    @(negedge clk);
    loadEn = 1'b0; instValid = 1'b0;
    check("R9 load priority", crOut, 32'h1234_5678);

    // R1: canonical encoding with all indices zero
    check("R1 canonical word", enc(19,129,0,0,0,0), 32'h4C00_0102);

    // R10: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 reset mid-run", crOut, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule